// File: doc/BRIEF.md
# Byte ALU with Per-Operation Condition Flags

This block is a purely combinational 8-bit arithmetic and logic unit. Two operand bytes and a 5-bit operation code go in. A result byte and five condition flags come out. There is no flag register, so every flag describes only the operation that is on the inputs now. A sequencer that wants a conditional branch selects the operation and one flag together, in the same step.

The 32 operations cover several groups:

- constants and copies;
- negation, increment and decrement;
- add and subtract, each with forward and reverse order and with carry-in and borrow-in forms;
- the low and high bytes of the product, quotient and remainder;
- shifts and rotates;
- bitwise logic;
- two-digit packed-decimal add and subtract.

The subtract forms are arranged so that one carry test, or one zero test, gives every ordered or equality comparison. One subtract returns the normal difference but inverts its zero flag, so a branch on that flag is a not-equal test. Carry out of an add feeds the carry-in add on the next byte pair, which gives multi-byte sums.

Top module: `byte_alu`

## Requirements
- R1: Codes 0 to 7 give, in order: 0, A, B, -A, -B, A+1, B+1, A-1. All results are taken modulo 256.
- R2: Codes 8 to 15 give, in order: B-1, A+B, A+B+1, A-B, A-B (code 12, with zero flag inverted), B-A, A-B-1, B-A-1. All results are taken modulo 256.
- R3: Code 16 returns bits 7:0 of the unsigned product A*B. Code 17 returns bits 15:8 of that product.
- R4: Code 18 returns the unsigned quotient A/B and code 19 returns A mod B. When B is 0, these two codes return 0 and raise the divide flag.
- R5: The shift amount is B[2:0]. The operations are: code 20 shifts left, code 21 shifts right logically, code 22 shifts right arithmetically, code 23 rotates left and code 24 rotates right.
- R6: Codes 25 to 29 give, in order: A AND B, A OR B, A XOR B, NOT A, NOT B.
- R7: The operands of codes 30 and 31 are two packed-decimal digits each, high digit in bits 7:4. Code 30 adds them: the result is the sum mod 100 and the carry flag shows a sum of 100 or more. Code 31 computes A-B: the result is the difference mod 100 and the carry flag shows a borrow.
- R8: The negative flag equals result bit 7. The zero flag is set when the result is 0. Code 12 is the exception: there the zero flag is set when the result is non-zero.
- R9: For the add codes (5, 6, 9, 10), the carry flag is the unsigned carry out of bit 7. For the subtract codes (3, 4, 7, 8, 11 to 15), it is the borrow. So the carry flag after code 13 means A>B, after code 14 means B>=A, and after code 15 means A>=B. For codes 0 to 2 and 16 to 29 the carry flag is 0.
- R10: The overflow flag shows signed two's-complement overflow for codes 3 to 15. It is 0 for all other codes.
- R11: The divide flag is 0 for every code other than 18 and 19, and is 0 for those two codes whenever B is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B (also shift amount) |
| op_i | input | 5 | Operation code |
| result_o | output | 8 | Result byte |
| flag_div0_o | output | 1 | Divide or modulo by zero |
| flag_neg_o | output | 1 | Result bit 7 |
| flag_ovf_o | output | 1 | Signed overflow |
| flag_carry_o | output | 1 | Carry out or borrow |
| flag_zero_o | output | 1 | Zero result (inverted for code 12) |

## Verification
Random operands almost never produce the cases that matter most here. Those cases are:

- a zero divisor;
- the signed limit 0x80 under negation or decrement;
- equal operands for the off-by-one borrow subtracts;
- packed-decimal digits that carry or borrow across both digits.

The stimulus therefore sweeps every code over a fixed grid of boundary operands: 0, 1, 0x7F, 0x80, 0xFF and 0x55. Grid values are mapped to valid decimal digits for the decimal codes. Hand-picked decimal wrap cases and a long random run follow the sweep.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int unsigned DW = 8;

    typedef enum logic [4:0] {
        OP_ZERO   = 5'd0,
        OP_PASSA  = 5'd1,
        OP_PASSB  = 5'd2,
        OP_NEGA   = 5'd3,
        OP_NEGB   = 5'd4,
        OP_INCA   = 5'd5,
        OP_INCB   = 5'd6,
        OP_DECA   = 5'd7,
        OP_DECB   = 5'd8,
        OP_ADD    = 5'd9,
        OP_ADDC   = 5'd10,
        OP_SUB    = 5'd11,
        OP_SUBNE  = 5'd12,
        OP_RSUB   = 5'd13,
        OP_SUBB   = 5'd14,
        OP_RSUBB  = 5'd15,
        OP_MULLO  = 5'd16,
        OP_MULHI  = 5'd17,
        OP_DIV    = 5'd18,
        OP_MOD    = 5'd19,
        OP_SHL    = 5'd20,
        OP_SHR    = 5'd21,
        OP_SAR    = 5'd22,
        OP_ROL    = 5'd23,
        OP_ROR    = 5'd24,
        OP_AND    = 5'd25,
        OP_OR     = 5'd26,
        OP_XOR    = 5'd27,
        OP_NOTA   = 5'd28,
        OP_NOTB   = 5'd29,
        OP_BCDADD = 5'd30,
        OP_BCDSUB = 5'd31
    } alu_op_e;

    // partial result from one operation unit
    typedef struct packed {
        logic [DW-1:0] res;
        logic          c;
        logic          v;
        logic          d;
    } part_t;

    // final result with all flags
    typedef struct packed {
        logic [DW-1:0] res;
        logic          d;
        logic          n;
        logic          v;
        logic          c;
        logic          z;
    } alu_out_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import byte_alu_pkg::*;
(
    input  alu_op_e        op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    output part_t          part_o
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] x_d, y_d, yy_d;
    logic          inv_d, cin_d, arith_d;
    logic [DW:0]   sum_d;

    always_comb begin
        x_d     = '0;
        y_d     = '0;
        inv_d   = 1'b0;
        cin_d   = 1'b0;
        arith_d = 1'b1;
        unique case (op_i)
            OP_ZERO:  arith_d = 1'b0;
            OP_PASSA: begin x_d = a_i; arith_d = 1'b0; end
            OP_PASSB: begin x_d = b_i; arith_d = 1'b0; end
            OP_NEGA:  begin y_d = a_i; inv_d = 1'b1; cin_d = 1'b1; end
            OP_NEGB:  begin y_d = b_i; inv_d = 1'b1; cin_d = 1'b1; end
            OP_INCA:  begin x_d = a_i; cin_d = 1'b1; end
            OP_INCB:  begin x_d = b_i; cin_d = 1'b1; end
            OP_DECA:  begin x_d = a_i; y_d = ONE; inv_d = 1'b1; cin_d = 1'b1; end
            OP_DECB:  begin x_d = b_i; y_d = ONE; inv_d = 1'b1; cin_d = 1'b1; end
            OP_ADD:   begin x_d = a_i; y_d = b_i; end
            OP_ADDC:  begin x_d = a_i; y_d = b_i; cin_d = 1'b1; end
            OP_SUB,
            OP_SUBNE: begin x_d = a_i; y_d = b_i; inv_d = 1'b1; cin_d = 1'b1; end
            OP_RSUB:  begin x_d = b_i; y_d = a_i; inv_d = 1'b1; cin_d = 1'b1; end
            OP_SUBB:  begin x_d = a_i; y_d = b_i; inv_d = 1'b1; end
            OP_RSUBB: begin x_d = b_i; y_d = a_i; inv_d = 1'b1; end
            default:  arith_d = 1'b0;
        endcase
        yy_d  = inv_d ? ~y_d : y_d;
        sum_d = {1'b0, x_d} + {1'b0, yy_d} + {{DW{1'b0}}, cin_d};

        part_o.res = sum_d[DW-1:0];
        // borrow is the complement of carry out for subtract forms
        part_o.c   = arith_d & (inv_d ? ~sum_d[DW] : sum_d[DW]);
        part_o.v   = arith_d & (x_d[DW-1] == yy_d[DW-1])
                             & (sum_d[DW-1] != x_d[DW-1]);
        part_o.d   = 1'b0;
    end

endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv
    import byte_alu_pkg::*;
(
    input  alu_op_e        op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    output part_t          part_o
);
    logic [2*DW-1:0] prod_d;
    logic [DW-1:0]   den_d, quo_d, rem_d;
    logic            zero_den_d;

    always_comb begin
        prod_d     = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
        zero_den_d = (b_i == '0);
        den_d      = zero_den_d ? DW'(1) : b_i;
        quo_d      = a_i / den_d;
        rem_d      = a_i % den_d;

        part_o = '0;
        unique case (op_i)
            OP_MULLO: part_o.res = prod_d[DW-1:0];
            OP_MULHI: part_o.res = prod_d[2*DW-1:DW];
            OP_DIV: begin
                part_o.res = zero_den_d ? '0 : quo_d;
                part_o.d   = zero_den_d;
            end
            OP_MOD: begin
                part_o.res = zero_den_d ? '0 : rem_d;
                part_o.d   = zero_den_d;
            end
            default: part_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import byte_alu_pkg::*;
#(
    parameter int unsigned AW = $clog2(DW)
)(
    input  alu_op_e        op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [AW-1:0]  amt_i,
    output part_t          part_o
);
    logic [2*DW-1:0] rol_w_d, ror_w_d;
    logic [DW-1:0]   sar_d;

    always_comb begin
        rol_w_d = {a_i, a_i} << amt_i;
        ror_w_d = {a_i, a_i} >> amt_i;
        sar_d   = $signed(a_i) >>> amt_i;

        part_o = '0;
        unique case (op_i)
            OP_SHL:  part_o.res = a_i << amt_i;
            OP_SHR:  part_o.res = a_i >> amt_i;
            OP_SAR:  part_o.res = sar_d;
            OP_ROL:  part_o.res = rol_w_d[2*DW-1:DW];
            OP_ROR:  part_o.res = ror_w_d[DW-1:0];
            default: part_o.res = '0;
        endcase
    end

endmodule

// File: rtl/alu_logic_bcd.sv
module alu_logic_bcd
    import byte_alu_pkg::*;
#(
    parameter int unsigned DIGITS = DW / 4
)(
    input  alu_op_e        op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    output part_t          part_o
);
    logic [DW-1:0] add_d, sub_d;
    logic          add_cy_d, sub_br_d;

    // digit-serial decimal adder and subtractor
    always_comb begin
        logic [4:0] t_add, t_sub;
        logic       cy, br;
        cy = 1'b0;
        br = 1'b0;
        add_d = '0;
        sub_d = '0;
        for (int g = 0; g < DIGITS; g++) begin
            t_add = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'd0, cy};
            if (t_add > 5'd9) begin
                t_add = t_add + 5'd6;
                cy    = 1'b1;
            end else begin
                cy    = 1'b0;
            end
            add_d[4*g +: 4] = t_add[3:0];

            t_sub = {1'b0, a_i[4*g +: 4]} - {1'b0, b_i[4*g +: 4]} - {4'd0, br};
            if (t_sub[4]) begin
                t_sub = t_sub + 5'd10;
                br    = 1'b1;
            end else begin
                br    = 1'b0;
            end
            sub_d[4*g +: 4] = t_sub[3:0];
        end
        add_cy_d = cy;
        sub_br_d = br;
    end

    always_comb begin
        part_o = '0;
        unique case (op_i)
            OP_AND:    part_o.res = a_i & b_i;
            OP_OR:     part_o.res = a_i | b_i;
            OP_XOR:    part_o.res = a_i ^ b_i;
            OP_NOTA:   part_o.res = ~a_i;
            OP_NOTB:   part_o.res = ~b_i;
            OP_BCDADD: begin part_o.res = add_d; part_o.c = add_cy_d; end
            OP_BCDSUB: begin part_o.res = sub_d; part_o.c = sub_br_d; end
            default:   part_o = '0;
        endcase
    end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
(
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    input  logic [4:0] op_i,
    output logic [7:0] result_o,
    output logic       flag_div0_o,
    output logic       flag_neg_o,
    output logic       flag_ovf_o,
    output logic       flag_carry_o,
    output logic       flag_zero_o
);
    localparam int unsigned AW = $clog2(DW);

    alu_op_e  op;
    part_t    arith_p, muldiv_p, shift_p, logic_p, sel_p;
    alu_out_t out_d;

    assign op = alu_op_e'(op_i);

    alu_addsub u_addsub (
        .op_i(op), .a_i(a_i), .b_i(b_i), .part_o(arith_p)
    );

    alu_muldiv u_muldiv (
        .op_i(op), .a_i(a_i), .b_i(b_i), .part_o(muldiv_p)
    );

    alu_shift #(.AW(AW)) u_shift (
        .op_i(op), .a_i(a_i), .amt_i(b_i[AW-1:0]), .part_o(shift_p)
    );

    alu_logic_bcd u_logic (
        .op_i(op), .a_i(a_i), .b_i(b_i), .part_o(logic_p)
    );

    always_comb begin
        if (!op_i[4])
            sel_p = arith_p;
        else if (op <= OP_MOD)
            sel_p = muldiv_p;
        else if (op <= OP_ROR)
            sel_p = shift_p;
        else
            sel_p = logic_p;

        out_d.res = sel_p.res;
        out_d.d   = sel_p.d;
        out_d.v   = sel_p.v;
        out_d.c   = sel_p.c;
        out_d.n   = sel_p.res[DW-1];
        out_d.z   = (sel_p.res == '0) ^ (op == OP_SUBNE);
    end

    assign result_o     = out_d.res;
    assign flag_div0_o  = out_d.d;
    assign flag_neg_o   = out_d.n;
    assign flag_ovf_o   = out_d.v;
    assign flag_carry_o = out_d.c;
    assign flag_zero_o  = out_d.z;

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
    import byte_alu_pkg::*;
(
    input logic [7:0] a_i,
    input logic [7:0] b_i,
    input logic [4:0] op_i,
    input logic [7:0] result_o,
    input logic       flag_div0_o,
    input logic       flag_ovf_o,
    input logic       flag_carry_o,
    input logic       flag_zero_o
);
    always_comb begin
        // R4 R11
        div_flag_chk: assert (!flag_div0_o ||
                              ((op_i == OP_DIV || op_i == OP_MOD) && b_i == '0))
            else $error("divide flag outside zero-divisor case");
        // R4
        div_zero_res_chk: assert (!flag_div0_o || result_o == '0)
            else $error("divide by zero result not forced to 0");
        // R10
        no_overflow_chk: assert (op_i < OP_MULLO || !flag_ovf_o)
            else $error("overflow flag on non-arithmetic code");
        // R8
        subne_zero_chk: assert (op_i != OP_SUBNE || flag_zero_o == (result_o != '0))
            else $error("inverted zero flag wrong");
        // R1
        pass_a_chk: assert (op_i != OP_PASSA ||
                            (result_o == a_i && !flag_carry_o && !flag_ovf_o))
            else $error("copy of A wrong");
    end
endmodule

bind byte_alu byte_alu_chk u_chk (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .result_o(result_o),
    .flag_div0_o(flag_div0_o), .flag_ovf_o(flag_ovf_o),
    .flag_carry_o(flag_carry_o), .flag_zero_o(flag_zero_o)
);

// File: tb/byte_alu_bench.sv
module byte_alu_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [4:0] op;
        logic [7:0] a, b, res;
        logic       d, n, v, c, z;
    } item_t;

    logic       clk = 1'b0;
    logic [7:0] a = '0, b = '0;
    logic [4:0] op = '0;
    logic [7:0] result;
    logic       fd, fn, fv, fc, fz;
    int         checks = 0, errors = 0;
    bit         done = 0;
    item_t      q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_alu u_byte_alu (
        .a_i(a), .b_i(b), .op_i(op), .result_o(result),
        .flag_div0_o(fd), .flag_neg_o(fn), .flag_ovf_o(fv),
        .flag_carry_o(fc), .flag_zero_o(fz)
    );

    function automatic logic [7:0] to_bcd(int v);
        int m = v % 100;
        return 8'(((m / 10) << 4) | (m % 10));
    endfunction

    function automatic int from_bcd(logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic sovf(int s);
        return (s > 127) || (s < -128);
    endfunction

    // reference model written from the requirements
    function automatic item_t model(logic [4:0] o, logic [7:0] x, logic [7:0] y);
        item_t e;
        int ia = int'(x), ib = int'(y);
        int sa = int'($signed(x)), sb = int'($signed(y));
        int k = int'(y[2:0]);
        int r = 0, s = 0;
        e.op = o; e.a = x; e.b = y; e.d = 0; e.v = 0; e.c = 0;
        case (o)
            0:  r = 0;
            1:  r = ia;
            2:  r = ib;
            3:  begin r = -ia;  e.c = (ia != 0); e.v = sovf(-sa); end
            4:  begin r = -ib;  e.c = (ib != 0); e.v = sovf(-sb); end
            5:  begin r = ia+1; e.c = (r > 255); e.v = sovf(sa+1); end
            6:  begin r = ib+1; e.c = (r > 255); e.v = sovf(sb+1); end
            7:  begin r = ia-1; e.c = (ia == 0); e.v = sovf(sa-1); end
            8:  begin r = ib-1; e.c = (ib == 0); e.v = sovf(sb-1); end
            9:  begin r = ia+ib;   e.c = (r > 255); e.v = sovf(sa+sb); end
            10: begin r = ia+ib+1; e.c = (r > 255); e.v = sovf(sa+sb+1); end
            11, 12: begin r = ia-ib; e.c = (ia < ib); e.v = sovf(sa-sb); end
            13: begin r = ib-ia;   e.c = (ib < ia);  e.v = sovf(sb-sa); end
            14: begin r = ia-ib-1; e.c = (ia <= ib); e.v = sovf(sa-sb-1); end
            15: begin r = ib-ia-1; e.c = (ib <= ia); e.v = sovf(sb-sa-1); end
            16: r = ia*ib;
            17: r = (ia*ib) >> 8;
            18: if (ib == 0) begin r = 0; e.d = 1; end else r = ia / ib;
            19: if (ib == 0) begin r = 0; e.d = 1; end else r = ia % ib;
            20: r = ia << k;
            21: r = ia >> k;
            22: r = sa >>> k;
            23: r = (ia << k) | (ia >> (8-k));
            24: r = (ia >> k) | (ia << (8-k));
            25: r = ia & ib;
            26: r = ia | ib;
            27: r = ia ^ ib;
            28: r = ~ia;
            29: r = ~ib;
            30: begin
                s = from_bcd(x) + from_bcd(y);
                e.c = (s >= 100);
                r = int'(to_bcd(s));
            end
            default: begin
                s = from_bcd(x) - from_bcd(y);
                e.c = (s < 0);
                if (s < 0) s = s + 100;
                r = int'(to_bcd(s));
            end
        endcase
        e.res = 8'(r);
        e.n = e.res[7];
        e.z = (e.res == 0) ^ (o == 5'd12);
        return e;
    endfunction

    function automatic string res_tag(logic [4:0] o);
        if (o <= 7) return "R1";
        if (o <= 15) return "R2";
        if (o <= 17) return "R3";
        if (o <= 19) return "R4";
        if (o <= 24) return "R5";
        if (o <= 29) return "R6";
        return "R7";
    endfunction

    task automatic check(string tag, string what, item_t e, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag, what, e.op, e.a, e.b, act, exp);
        end
    endtask

    // driver: apply stimulus and queue the expected item
    task automatic apply(logic [4:0] o, logic [7:0] x, logic [7:0] y);
        @(posedge clk);
        op = o; a = x; b = y;
        q.push_back(model(o, x, y));
    endtask

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            check(res_tag(e.op), "result", e, result, e.res);
            check("R8", "neg", e, 8'(fn), 8'(e.n));
            check("R8", "zero", e, 8'(fz), 8'(e.z));
            check(e.op >= 30 ? "R7" : "R9", "carry", e, 8'(fc), 8'(e.c));
            check("R10", "ovf", e, 8'(fv), 8'(e.v));
            check((e.op == 18 || e.op == 19) ? "R4" : "R11", "div0", e, 8'(fd), 8'(e.d));
        end
    end

    initial begin
        logic [7:0] grid [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55};
        // idle state: code 0 with zero operands (R1, R8)
        apply(5'd0, 8'h00, 8'h00);
        // boundary sweep over all codes
        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    if (o >= 30) apply(5'(o), to_bcd(int'(grid[i])), to_bcd(int'(grid[j])));
                    else         apply(5'(o), grid[i], grid[j]);
        // R7 decimal wrap cases
        apply(5'd30, 8'h99, 8'h01);
        apply(5'd30, 8'h45, 8'h55);
        apply(5'd30, 8'h19, 8'h01);
        apply(5'd31, 8'h00, 8'h01);
        apply(5'd31, 8'h50, 8'h25);
        apply(5'd31, 8'h40, 8'h01);
        // R4 zero divisor and R9 equal-operand comparisons
        apply(5'd18, 8'hC3, 8'h00);
        apply(5'd19, 8'h00, 8'h00);
        apply(5'd14, 8'h42, 8'h42);
        apply(5'd15, 8'h42, 8'h42);
        apply(5'd13, 8'h43, 8'h42);
        // R5 shift amounts above 7 wrap
        apply(5'd23, 8'h81, 8'h09);
        apply(5'd22, 8'h80, 8'h0F);
        // random run
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] o = 5'($urandom_range(0, 31));
            logic [7:0] x = 8'($urandom), y = 8'($urandom);
            if (o >= 30) apply(o, to_bcd(int'(x)), to_bcd(int'(y)));
            else         apply(o, x, y);
        end
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule